// File: doc/BRIEF.md
# Counted Block Memory Copy Engine

This engine moves a block of bytes from one region of memory to another, as one step of a processor's execution. A single start pulse loads a 16-bit source pointer, a 16-bit destination pointer and an 8-bit count. For each byte, the engine reads from the source address and writes that byte to the destination address. It then advances both pointers by one and lowers the count by one.

The loop does not stop when the count reaches zero. It stops when lowering the count would borrow. A starting count of n therefore moves n+1 bytes, and a starting count of 0xFF moves 256 bytes. Every byte takes a fixed slot of 13 clock cycles, so a whole copy takes 13 × (n+1) cycles.

When the copy ends, the engine raises a done pulse for one cycle. At that point its outputs hold the final pointer and count values. The memory port has one cycle of read latency.

Top module: `blkcopy_engine`

## Requirements
- R1: After reset, and after any reset that arrives during a copy, `busy_o`, `done_o`, `mem_rd_o` and `mem_we_o` are all 0.
- R2: A start pulse seen while idle loads the three inputs. In the next cycle `busy_o` is 1, and `mem_rd_o` is 1 with `mem_addr_o` equal to the loaded source pointer.
- R3: In each slot, the read happens in slot cycle 0 at the current source pointer. The write happens in slot cycle 2, at the current destination pointer, and carries the byte that the read returned.
- R4: Both pointers go up by one at the end of every slot. They wrap from 0xFFFF to 0x0000 without any other effect.
- R5: The count goes down by one at the end of every slot. The copy ends with the slot that starts with a count of 0, so n+1 bytes move and the final count is 0xFF.
- R6: `busy_o` stays at 1 for exactly 13 × (n+1) cycles.
- R7: `done_o` is 1 for exactly one cycle, in the cycle right after the last busy cycle. In that cycle `busy_o` is 0, `src_o` is the source start value plus n+1, and `dst_o` is the destination start value plus n+1.
- R8: A start pulse while busy is ignored. The pointers, the count and the transfer sequence do not change.
- R9: There is exactly one read and one write per slot, never both in the same cycle, and neither strobe is raised while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only when idle |
| src_i | input | 16 | Initial source pointer |
| dst_i | input | 16 | Initial destination pointer |
| cnt_i | input | 8 | Initial count (moves cnt_i+1 bytes) |
| mem_addr_o | output | 16 | Memory address |
| mem_rd_o | output | 1 | Read strobe; data returns one cycle later |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-cycle completion pulse |
| src_o | output | 16 | Current or final source pointer |
| dst_o | output | 16 | Current or final destination pointer |
| cnt_o | output | 8 | Current or final count |

## Verification
The hardest case to reach from the ports is the borrow boundary when it coincides with a pointer wrap. This is the last slot of a copy whose pointers cross 0xFFFF, or of a copy that starts with a count of 0 or 0xFF. The stimulus table places the start pointers just below 0xFFFF and includes counts of zero and full range. The bench returns each read byte as a function of its address, so every write can be traced back to its own source address. A spurious start pulse with different values is injected in the middle of several copies, to show that it leaves the transfer stream unchanged.

// File: rtl/blkcopy_pkg.sv
package blkcopy_pkg;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [DATA_W-1:0] data_t;

  // Pointer advance, modulo 2^ADDR_W
  function automatic addr_t ptr_advance(addr_t p);
    return p + addr_t'(1);
  endfunction

  // Count decrement, wraps 0 -> all ones
  function automatic cnt_t cnt_decrement(cnt_t c);
    return c - cnt_t'(1);
  endfunction

  // True when decrementing this value would borrow
  function automatic logic cnt_borrows(cnt_t c);
    return c == '0;
  endfunction
endpackage

// File: rtl/blkcopy_phase.sv
module blkcopy_phase #(
  parameter int SLOT_STATES = 13,
  parameter int RD_PHASE    = 0,
  parameter int WR_PHASE    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic rd_slot,
  output logic latch_slot,
  output logic wr_slot,
  output logic end_slot
);
  localparam int PH_W        = $clog2(SLOT_STATES);
  localparam int LATCH_PHASE = RD_PHASE + 1;
  localparam int LAST_PHASE  = SLOT_STATES - 1;

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      ph_q <= '0;
    else if (clear)
      ph_q <= '0;
    else if (run)
      ph_q <= (ph_q == PH_W'(LAST_PHASE)) ? '0 : ph_q + PH_W'(1);
  end

  assign rd_slot    = run && (ph_q == PH_W'(RD_PHASE));
  assign latch_slot = run && (ph_q == PH_W'(LATCH_PHASE));
  assign wr_slot    = run && (ph_q == PH_W'(WR_PHASE));
  assign end_slot   = run && (ph_q == PH_W'(LAST_PHASE));
endmodule

// File: rtl/blkcopy_datapath.sv
module blkcopy_datapath
  import blkcopy_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  step,
  input  logic  latch,
  input  addr_t src_in,
  input  addr_t dst_in,
  input  cnt_t  cnt_in,
  input  data_t rdata,
  output addr_t src_q,
  output addr_t dst_q,
  output cnt_t  cnt_q,
  output data_t data_q,
  output logic  last_byte
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      src_q <= src_in;
      dst_q <= dst_in;
      cnt_q <= cnt_in;
    end else if (step) begin
      src_q <= ptr_advance(src_q);
      dst_q <= ptr_advance(dst_q);
      cnt_q <= cnt_decrement(cnt_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      data_q <= '0;
    else if (latch)
      data_q <= rdata;
  end

  assign last_byte = cnt_borrows(cnt_q);
endmodule

// File: rtl/blkcopy_engine.sv
module blkcopy_engine
  import blkcopy_pkg::*;
#(
  parameter int SLOT_STATES = 13,
  parameter int RD_PHASE    = 0,
  parameter int WR_PHASE    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic  busy_q, done_q;
  logic  accept, finish;
  logic  rd_slot, latch_slot, wr_slot, slot_end, last_byte;
  addr_t src_q, dst_q;
  cnt_t  cnt_q;
  data_t data_q;

  assign accept = start_i && !busy_q;
  assign finish = slot_end && last_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept)
        busy_q <= 1'b1;
      else if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  blkcopy_phase #(
    .SLOT_STATES(SLOT_STATES),
    .RD_PHASE   (RD_PHASE),
    .WR_PHASE   (WR_PHASE)
  ) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (accept),
    .run       (busy_q),
    .rd_slot   (rd_slot),
    .latch_slot(latch_slot),
    .wr_slot   (wr_slot),
    .end_slot  (slot_end)
  );

  blkcopy_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .step     (slot_end),
    .latch    (latch_slot),
    .src_in   (src_i),
    .dst_in   (dst_i),
    .cnt_in   (cnt_i),
    .rdata    (mem_rdata_i),
    .src_q    (src_q),
    .dst_q    (dst_q),
    .cnt_q    (cnt_q),
    .data_q   (data_q),
    .last_byte(last_byte)
  );

  assign mem_addr_o  = wr_slot ? dst_q : src_q;
  assign mem_rd_o    = rd_slot;
  assign mem_we_o    = wr_slot;
  assign mem_wdata_o = data_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign src_o       = src_q;
  assign dst_o       = dst_q;
  assign cnt_o       = cnt_q;
endmodule

// File: rtl/blkcopy_chk.sv
module blkcopy_chk
  import blkcopy_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  slot_end,
  input logic  mem_rd_o,
  input logic  mem_we_o,
  input logic  busy_o,
  input logic  done_o,
  input addr_t src_o,
  input addr_t dst_o,
  input cnt_t  cnt_o
);
  // R1 / R9: no strobes while idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_rd_o && !mem_we_o));

  // R9: read and write never together
  a_r9_rd_we_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_we_o));

  // R3: a write comes two cycles after a read
  a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> $past(mem_rd_o, 2));

  // R4: both pointers advance by one at the end of a slot
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && !done_o) |=> (src_o == ADDR_W'($past(src_o) + 1'b1)) &&
                              (dst_o == ADDR_W'($past(dst_o) + 1'b1)));

  // R5: count steps down by one per slot
  a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |=> cnt_o == CNT_W'($past(cnt_o) - 1'b1));

  // R5: a slot that starts at count zero ends the copy
  a_r5_stop_on_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && cnt_o == '0) |=> (!busy_o && done_o));

  // R7: done is a single-cycle pulse right after busy
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(busy_o) && !busy_o));

  // R8: state holds inside a slot whatever start does
  a_r8_hold_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !slot_end) |=> ($stable(src_o) && $stable(dst_o) && $stable(cnt_o)));
endmodule

bind blkcopy_engine blkcopy_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .slot_end(slot_end),
  .mem_rd_o(mem_rd_o),
  .mem_we_o(mem_we_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .src_o   (src_o),
  .dst_o   (dst_o),
  .cnt_o   (cnt_o)
);

// File: tb/blkcopy_engine_bench.sv
`timescale 1ns/1ps
module blkcopy_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] src_i = '0, dst_i = '0;
  logic [7:0]  cnt_i = '0;
  logic [15:0] mem_addr_o;
  logic        mem_rd_o, mem_we_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i = '0;
  logic        busy_o, done_o;
  logic [15:0] src_o, dst_o;
  logic [7:0]  cnt_o;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  blkcopy_engine u_blkcopy_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_i(src_i), .dst_i(dst_i),
    .cnt_i(cnt_i), .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_we_o(mem_we_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .busy_o(busy_o),
    .done_o(done_o), .src_o(src_o), .dst_o(dst_o), .cnt_o(cnt_o)
  );

  // Memory content as a function of the address
  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  always_ff @(posedge clk)
    if (mem_rd_o) mem_rdata_i <= pat(mem_addr_o);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // src, dst, cnt, expected final src, expected final dst
  localparam int NVEC = 5;
  localparam logic [71:0] VEC [NVEC] = '{
    {16'h1000, 16'h2000, 8'h00, 16'h1001, 16'h2001},
    {16'h0100, 16'h0300, 8'h03, 16'h0104, 16'h0304},
    {16'hFFFE, 16'h7FFC, 8'h05, 16'h0004, 16'h8002},
    {16'h4000, 16'hFFF0, 8'h1F, 16'h4020, 16'h0010},
    {16'hABCD, 16'h1234, 8'h0A, 16'hABD8, 16'h123F}
  };

  task automatic run_copy(input logic [15:0] s, input logic [15:0] d, input logic [7:0] n,
                          input logic [15:0] es, input logic [15:0] ed, input bit poke);
    int nbusy = 0, nrd = 0, nwr = 0, rderr = 0, wrerr = 0, guard = 0;
    @(negedge clk);
    src_i = s; dst_i = d; cnt_i = n; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && mem_rd_o && mem_addr_o == s, "R2 first read",
        {busy_o, mem_rd_o, mem_addr_o}, {2'b11, s});
    while (!done_o && guard < 5000) begin
      guard++;
      if (busy_o) nbusy++;
      if (mem_rd_o) begin
        if (mem_addr_o != 16'(s + nrd)) rderr++;
        nrd++;
      end
      if (mem_we_o) begin
        if (mem_addr_o != 16'(d + nwr) || mem_wdata_o != pat(16'(s + nwr))) wrerr++;
        nwr++;
      end
      if (poke && nbusy == 7) begin
        start_i = 1'b1; src_i = 16'hDEAD; dst_i = 16'hBEEF; cnt_i = 8'h40;
      end else start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(done_o, "R7 done seen", done_o, 1);
    chk(!busy_o, "R7 busy low at done", busy_o, 0);
    chk(src_o == es && dst_o == ed, "R4 final pointers", {src_o, dst_o}, {es, ed});
    chk(cnt_o == 8'hFF, "R5 final count", cnt_o, 8'hFF);
    chk(nbusy == 13 * (int'(n) + 1), "R6 busy cycles", nbusy, 13 * (int'(n) + 1));
    chk(nrd == int'(n) + 1 && nwr == int'(n) + 1, "R9 one read and write per byte",
        {nrd[15:0], nwr[15:0]}, {16'(n + 1), 16'(n + 1)});
    chk(rderr == 0, "R3 read addresses", rderr, 0);
    chk(wrerr == 0, poke ? "R8 stream unaffected by start" : "R3 write addr/data", wrerr, 0);
    @(negedge clk);
    chk(!done_o, "R7 done one cycle", done_o, 0);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL R7 watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !mem_rd_o && !mem_we_o, "R1 reset state",
        {busy_o, done_o, mem_rd_o, mem_we_o}, 0);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(!mem_rd_o && !mem_we_o && !busy_o, "R9 idle quiet",
          {mem_rd_o, mem_we_o, busy_o}, 0);
    end

    for (int i = 0; i < NVEC; i++)
      run_copy(VEC[i][71:56], VEC[i][55:40], VEC[i][39:32], VEC[i][31:16],
               VEC[i][15:0], (i % 2) == 1);

    // R5: full count moves 256 bytes across a wrap
    run_copy(16'hFF80, 16'h0040, 8'hFF, 16'h0080, 16'h0140, 1'b1);

    // R1: reset in the middle of a copy
    @(negedge clk);
    src_i = 16'h0200; dst_i = 16'h0400; cnt_i = 8'h10; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o && !mem_rd_o && !mem_we_o, "R1 reset during copy",
        {busy_o, done_o, mem_rd_o, mem_we_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !done_o, "R1 stays idle after reset", {busy_o, done_o}, 0);

    // Restart after mid-copy reset
    run_copy(16'hFFFF, 16'hFFFF, 8'h02, 16'h0002, 16'h0002, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule